// File: doc/BRIEF.md
# Multidrop TAP Connection Switch Controller

This block joins one shared, multidrop primary IEEE 1149.1 test access port to a single local secondary TAP. It follows the primary TAP controller state from the primary test clock and mode select. It keeps a link status of RESET, OFF, ON or MULTICAST. When the link is open, the primary mode select and data input reach the secondary side, and the secondary data comes back to the primary data output, with no storage element in any of these paths. The test clock and test reset always pass through to the secondary side unchanged.

The serial address protocol is decoded by a separate block. That decoder gives this block four command strobes (reset, disconnect, multicast, connect), plus an acknowledge-active flag and an acknowledge data bit. The commands are sampled on the rising edge of the primary clock. They are honoured only in a stable TAP state, and multicast is honoured only in Pause-DR or Pause-IR.

An active-low bypass input opens the link at once, whatever the clock or reset is doing. The active-low connect indicator reports an open link, whether the link was opened by command or by bypass.

Top module: `tap_link_switch`

## Requirements
- R1: While ptrst_n is low and byp_n is high, the block is in RESET: con_n=1, stms=1, stdo_oe=0, and ptdo_oe=0 unless an acknowledge is active.
- R2: stck always equals ptck, and strst_n always equals ptrst_n, in every status.
- R3: In ON (no bypass, no acknowledge), the outputs follow their inputs combinationally: stms=ptms, stdo=ptdi with stdo_oe=1, and ptdo=stdi with ptdo_oe=1.
- R4: In OFF, stdo_oe=0. With byp_n high, ptdo_oe is 1 exactly while ack_active is 1, and ptdo then carries ack_bit. The acknowledge takes priority over stdi in every status.
- R5: In OFF, stms holds the ptms level that was sampled at the last rising ptck edge while the link was open, and ignores later changes on ptms.
- R6: A reset command puts the block in RESET, where stms is driven to 1.
- R7: In MULTICAST, stms=ptms, stdo=ptdi with stdo_oe=1, ptdo_oe=0 (unless an acknowledge is active) and con_n=0. A multicast command is honoured only in Pause-DR or Pause-IR.
- R8: While byp_n is low, the link is open and con_n=0 asynchronously, regardless of ptrst_n. All commands are ignored, so the status is unchanged when bypass is released.
- R9: Commands take effect at the rising ptck edge. They take effect only when the TAP is in Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR. The priority order is reset, then disconnect, then multicast, then connect.
- R10: A 16-state TAP controller, clocked on the rising ptck edge and cleared asynchronously to Test-Logic-Reset by ptrst_n, drives st_tlr, st_rti, st_pdr and st_pir high in their respective states.
- R11: con_n is 0 in ON, in MULTICAST and in bypass, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ptck | input | 1 | Primary test clock |
| ptrst_n | input | 1 | Primary test reset, active low |
| ptms | input | 1 | Primary mode select |
| ptdi | input | 1 | Primary data in |
| ptdo | output | 1 | Primary data out value |
| ptdo_oe | output | 1 | Primary data out drive enable |
| stdi | input | 1 | Secondary data in |
| stck | output | 1 | Secondary test clock |
| strst_n | output | 1 | Secondary test reset, active low |
| stms | output | 1 | Secondary mode select |
| stdo | output | 1 | Secondary data out value |
| stdo_oe | output | 1 | Secondary data out drive enable |
| byp_n | input | 1 | Bypass override, active low |
| cmd_reset | input | 1 | Decoder: reset command |
| cmd_disconnect | input | 1 | Decoder: disconnect command |
| cmd_multicast | input | 1 | Decoder: multicast command |
| cmd_connect | input | 1 | Decoder: connect command |
| ack_active | input | 1 | Decoder: acknowledge in progress |
| ack_bit | input | 1 | Decoder: acknowledge data bit |
| con_n | output | 1 | Link open indicator, active low |
| st_tlr | output | 1 | TAP in Test-Logic-Reset |
| st_rti | output | 1 | TAP in Run-Test/Idle |
| st_pdr | output | 1 | TAP in Pause-DR |
| st_pir | output | 1 | TAP in Pause-IR |

## Verification
A wrong link status shows in the same cycle as a wrong con_n level and a wrong stdo_oe or ptdo_oe. A wrong TAP state shows only once a command arrives: the command is then accepted or refused wrongly, which con_n reveals one ptck edge later. A stale park register shows as soon as ptms moves after a disconnect, so the bench toggles ptms inside a half cycle to expose it. Bypass is checked between clock edges, so that no synchronous path can hide a missing asynchronous one.

// File: rtl/tap_link_switch.sv
module tap_link_switch (
  input  logic ptck,
  input  logic ptrst_n,
  input  logic ptms,
  input  logic ptdi,
  output logic ptdo,
  output logic ptdo_oe,
  input  logic stdi,
  output logic stck,
  output logic strst_n,
  output logic stms,
  output logic stdo,
  output logic stdo_oe,
  input  logic byp_n,
  input  logic cmd_reset,
  input  logic cmd_disconnect,
  input  logic cmd_multicast,
  input  logic cmd_connect,
  input  logic ack_active,
  input  logic ack_bit,
  output logic con_n,
  output logic st_tlr,
  output logic st_rti,
  output logic st_pdr,
  output logic st_pir
);

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_e;

  typedef enum logic [1:0] {LK_RESET, LK_OFF, LK_ON, LK_MC} link_e;

  tap_e  tap_q, tap_d;
  link_e link_q, link_d;
  logic  held_q;

  always_comb begin
    unique case (tap_q)
      TLR:     tap_d = ptms ? TLR    : RTI;
      RTI:     tap_d = ptms ? SEL_DR : RTI;
      SEL_DR:  tap_d = ptms ? SEL_IR : CAP_DR;
      CAP_DR:  tap_d = ptms ? EX1_DR : SH_DR;
      SH_DR:   tap_d = ptms ? EX1_DR : SH_DR;
      EX1_DR:  tap_d = ptms ? UPD_DR : PAU_DR;
      PAU_DR:  tap_d = ptms ? EX2_DR : PAU_DR;
      EX2_DR:  tap_d = ptms ? UPD_DR : SH_DR;
      UPD_DR:  tap_d = ptms ? SEL_DR : RTI;
      SEL_IR:  tap_d = ptms ? TLR    : CAP_IR;
      CAP_IR:  tap_d = ptms ? EX1_IR : SH_IR;
      SH_IR:   tap_d = ptms ? EX1_IR : SH_IR;
      EX1_IR:  tap_d = ptms ? UPD_IR : PAU_IR;
      PAU_IR:  tap_d = ptms ? EX2_IR : PAU_IR;
      EX2_IR:  tap_d = ptms ? UPD_IR : SH_IR;
      default: tap_d = ptms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge ptck or negedge ptrst_n)
    if (!ptrst_n) tap_q <= TLR;
    else          tap_q <= tap_d;

  assign st_tlr = (tap_q == TLR);
  assign st_rti = (tap_q == RTI);
  assign st_pdr = (tap_q == PAU_DR);
  assign st_pir = (tap_q == PAU_IR);

  logic stable, pause, bypass, fwd, full, ack_on;
  assign stable = st_tlr | st_rti | st_pdr | st_pir;
  assign pause  = st_pdr | st_pir;
  assign bypass = ~byp_n;
  assign fwd    = bypass | (link_q == LK_ON) | (link_q == LK_MC);
  assign full   = bypass | (link_q == LK_ON);
  assign ack_on = byp_n & ack_active;

  always_comb begin
    link_d = link_q;
    if (byp_n && stable) begin
      if (cmd_reset)                   link_d = LK_RESET;
      else if (cmd_disconnect)         link_d = LK_OFF;
      else if (cmd_multicast && pause) link_d = LK_MC;
      else if (cmd_connect)            link_d = LK_ON;
    end
  end

  always_ff @(posedge ptck or negedge ptrst_n)
    if (!ptrst_n) link_q <= LK_RESET;
    else          link_q <= link_d;

  always_ff @(posedge ptck or negedge ptrst_n)
    if (!ptrst_n)  held_q <= 1'b1;
    else if (fwd)  held_q <= ptms;

  assign stck    = ptck;
  assign strst_n = ptrst_n;
  assign stms    = fwd ? ptms : ((link_q == LK_RESET) ? 1'b1 : held_q);
  assign stdo_oe = fwd;
  assign stdo    = fwd & ptdi;
  assign ptdo_oe = ack_on | full;
  assign ptdo    = ack_on ? ack_bit : (full & stdi);
  assign con_n   = ~fwd;

endmodule

// File: rtl/tap_link_switch_chk.sv
module tap_link_switch_chk (
  input logic       ptck,
  input logic       ptrst_n,
  input logic       ptms,
  input logic       byp_n,
  input logic       ack_active,
  input logic [1:0] link,
  input logic       stms,
  input logic       con_n,
  input logic       stdo_oe,
  input logic       ptdo_oe,
  input logic       st_tlr,
  input logic       st_pdr,
  input logic       st_pir
);
  localparam logic [1:0] OFF = 2'd1;
  localparam logic [1:0] MC  = 2'd3;

  always @(posedge ptck)
    if (!ptrst_n && byp_n)
      // R1
      r1_reset_cond_chk: assert (con_n && stms && !stdo_oe);

  // R5
  r5_stms_park_chk: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (byp_n && $past(byp_n) && link == OFF && $past(link) == OFF) |-> $stable(stms));

  // R7
  r7_mcast_quiet_chk: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (byp_n && link == MC && !ack_active) |-> (!ptdo_oe && stdo_oe && !con_n));

  // R7
  r7_mcast_pause_only_chk: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (byp_n && link != MC && !st_pdr && !st_pir) |=> (link != MC));

  // R8
  r8_bypass_freeze_chk: assert property (@(posedge ptck) disable iff (!ptrst_n)
    $past(!byp_n) |-> $stable(link));

  // R10
  r10_tlr_hold_chk: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (st_tlr && ptms) |=> st_tlr);
endmodule

bind tap_link_switch tap_link_switch_chk chk_i (
  .ptck(ptck), .ptrst_n(ptrst_n), .ptms(ptms), .byp_n(byp_n),
  .ack_active(ack_active), .link(link_q), .stms(stms), .con_n(con_n),
  .stdo_oe(stdo_oe), .ptdo_oe(ptdo_oe), .st_tlr(st_tlr),
  .st_pdr(st_pdr), .st_pir(st_pir)
);

// File: tb/tap_link_switch_tb_top.sv
`timescale 1ns/100ps
module tap_link_switch_tb_top;
  logic ptck = 1'b0, ptrst_n = 1'b0, ptms = 1'b1, ptdi = 1'b0, stdi = 1'b0;
  logic byp_n = 1'b1, cmd_reset = 1'b0, cmd_disconnect = 1'b0;
  logic cmd_multicast = 1'b0, cmd_connect = 1'b0, ack_active = 1'b0, ack_bit = 1'b0;
  logic ptdo, ptdo_oe, stck, strst_n, stms, stdo, stdo_oe, con_n;
  logic st_tlr, st_rti, st_pdr, st_pir;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 ptck = ~ptck;

  tap_link_switch dut_i (
    .ptck(ptck), .ptrst_n(ptrst_n), .ptms(ptms), .ptdi(ptdi), .ptdo(ptdo),
    .ptdo_oe(ptdo_oe), .stdi(stdi), .stck(stck), .strst_n(strst_n),
    .stms(stms), .stdo(stdo), .stdo_oe(stdo_oe), .byp_n(byp_n),
    .cmd_reset(cmd_reset), .cmd_disconnect(cmd_disconnect),
    .cmd_multicast(cmd_multicast), .cmd_connect(cmd_connect),
    .ack_active(ack_active), .ack_bit(ack_bit), .con_n(con_n),
    .st_tlr(st_tlr), .st_rti(st_rti), .st_pdr(st_pdr), .st_pir(st_pir)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input logic ms);
    @(negedge ptck); ptms = ms;
    @(posedge ptck); #1;
  endtask

  task automatic cmd(input logic r, input logic d, input logic m, input logic c);
    @(negedge ptck);
    cmd_reset = r; cmd_disconnect = d; cmd_multicast = m; cmd_connect = c;
    @(posedge ptck); #1;
    cmd_reset = 0; cmd_disconnect = 0; cmd_multicast = 0; cmd_connect = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge ptck);
    #1;
    chk("R1 con_n", con_n, 1'b1);
    chk("R1 stms", stms, 1'b1);
    chk("R1 stdo_oe", stdo_oe, 1'b0);
    chk("R1 ptdo_oe", ptdo_oe, 1'b0);
    chk("R10 st_tlr", st_tlr, 1'b1);
    chk("R2 strst_n low", strst_n, 1'b0);
    chk("R2 stck high", stck, 1'b1);
    @(negedge ptck); #0.5;
    chk("R2 stck low", stck, 1'b0);
    ptrst_n = 1'b1; #0.2;
    chk("R2 strst_n high", strst_n, 1'b1);
  endtask

  task automatic t_park_high;
    tick(1'b1);
    cmd(0, 0, 0, 1);
    chk("R11 con_n on", con_n, 1'b0);
    cmd(0, 1, 0, 0);
    chk("R11 con_n off", con_n, 1'b1);
    @(negedge ptck); ptms = 1'b0; #1;
    chk("R5 park high", stms, 1'b1);
    chk("R4 stdo_oe off", stdo_oe, 1'b0);
    chk("R4 ptdo_oe off", ptdo_oe, 1'b0);
    ack_active = 1'b1; ack_bit = 1'b1; #0.2;
    chk("R4 ack oe", ptdo_oe, 1'b1);
    chk("R4 ack one", ptdo, 1'b1);
    ack_bit = 1'b0; #0.2;
    chk("R4 ack zero", ptdo, 1'b0);
    ack_active = 1'b0; ptms = 1'b1;
    @(posedge ptck); #1;
    chk("R10 stay tlr", st_tlr, 1'b1);
  endtask

  task automatic t_forward;
    tick(1'b0);
    chk("R10 st_rti", st_rti, 1'b1);
    cmd(0, 0, 0, 1);
    chk("R11 con_n on", con_n, 1'b0);
    @(negedge ptck); ptms = 1'b1; ptdi = 1'b1; stdi = 1'b0; #1;
    chk("R3 stms", stms, 1'b1);
    chk("R3 stdo one", stdo, 1'b1);
    chk("R3 stdo_oe", stdo_oe, 1'b1);
    chk("R3 ptdo zero", ptdo, 1'b0);
    chk("R3 ptdo_oe", ptdo_oe, 1'b1);
    ptdi = 1'b0; stdi = 1'b1; #0.2;
    chk("R3 stdo zero", stdo, 1'b0);
    chk("R3 ptdo one", ptdo, 1'b1);
    ptms = 1'b0;
    cmd(0, 1, 0, 0);
    @(negedge ptck); ptms = 1'b1; #1;
    chk("R5 park low", stms, 1'b0);
    ptms = 1'b0;
  endtask

  task automatic t_mcast_rti;
    cmd(0, 0, 1, 0);
    chk("R7 mcast refused in rti", con_n, 1'b1);
  endtask

  task automatic t_shift;
    tick(1'b1); tick(1'b0); tick(1'b0);
    cmd(0, 0, 0, 1);
    chk("R9 refused in shift", con_n, 1'b1);
    tick(1'b1); tick(1'b0);
    chk("R10 st_pdr", st_pdr, 1'b1);
  endtask

  task automatic t_mcast_pdr;
    cmd(0, 0, 1, 0);
    chk("R7 mcast con_n", con_n, 1'b0);
    @(negedge ptck); ptdi = 1'b1; stdi = 1'b1; #1;
    chk("R7 stdo", stdo, 1'b1);
    chk("R7 stdo_oe", stdo_oe, 1'b1);
    chk("R7 ptdo_oe", ptdo_oe, 1'b0);
    chk("R7 stms", stms, 1'b0);
  endtask

  task automatic t_priority;
    cmd(0, 1, 0, 1);
    chk("R9 disconnect over connect", con_n, 1'b1);
    cmd(0, 0, 0, 1);
    chk("R9 connect", con_n, 1'b0);
    cmd(1, 0, 0, 1);
    chk("R6 reset over connect", con_n, 1'b1);
    chk("R6 stms high", stms, 1'b1);
  endtask

  task automatic t_mcast_pir;
    tick(1'b1); tick(1'b1); tick(1'b1); tick(1'b1);
    tick(1'b0); tick(1'b0); tick(1'b1); tick(1'b0);
    chk("R10 st_pir", st_pir, 1'b1);
    cmd(0, 0, 1, 0);
    chk("R7 mcast in pir", con_n, 1'b0);
    cmd(1, 0, 0, 0);
    chk("R6 reset cmd", con_n, 1'b1);
  endtask

  task automatic t_bypass;
    @(negedge ptck); ptrst_n = 1'b0; #0.5;
    byp_n = 1'b0; ptms = 1'b0; ptdi = 1'b1; stdi = 1'b0; #0.2;
    chk("R8 con_n", con_n, 1'b0);
    chk("R8 stms", stms, 1'b0);
    chk("R8 stdo", stdo, 1'b1);
    chk("R8 stdo_oe", stdo_oe, 1'b1);
    chk("R8 ptdo_oe", ptdo_oe, 1'b1);
    chk("R8 ptdo", ptdo, 1'b0);
    chk("R2 strst_n in bypass", strst_n, 1'b0);
    ptrst_n = 1'b1;
    cmd(0, 0, 0, 1);
    @(negedge ptck); byp_n = 1'b1; #0.2;
    chk("R8 cmd ignored con_n", con_n, 1'b1);
    chk("R8 cmd ignored stms", stms, 1'b1);
  endtask

  initial begin
    t_reset;
    t_park_high;
    t_forward;
    t_mcast_rti;
    t_shift;
    t_mcast_pdr;
    t_priority;
    t_mcast_pir;
    t_bypass;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge ptck);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule